// File: doc/BRIEF.md
# Commit-Stage Trap and Interrupt Controller

This block sits at the retirement point of an in-order pipeline and settles the fate of each instruction that reaches it. For every instruction it weighs the cause code carried down the pipeline together with a level-sensitive external interrupt request. It then does one of three things. It retires the instruction normally. It diverts control to the trap handler. Or, for a return-from-trap instruction, it jumps back to the saved return address. No other point in the pipeline acts on a trap or an interrupt. Earlier stages only record a cause and pass it along.

On trap entry the block loads the saved return address register and the cause register, and switches to privileged mode with interrupts masked. It then emits a one-cycle redirect to a fixed handler address, together with a flipped epoch bit that lets fetch discard wrong-path work. A return-from-trap unmasks interrupts, restores user mode and redirects to the saved address. Two combinational strobes drive the neighbouring logic. One lets the register-write and store path retire the instruction. The other tells the scoreboard to free the instruction's destination register.

Top module: `commit_trap_unit`

## Requirements
- R1: After reset, redirValid is 0, privMode is 0 (user), irqEnable is 1, causeOut is 0, epcOut is 0 and redirEpoch is 0.
- R2: A valid instruction with cause code 0 and no accepted interrupt, and which is not a return-from-trap, asserts commitFire and sbRelease in the same cycle. It causes no redirect and changes no state.
- R3: When an interrupt is accepted (extIrq high while irqEnable is 1) on a valid instruction with cause 0 that is not a return-from-trap, the instruction still retires: commitFire and sbRelease are high. On the next cycle epcOut equals instNextPc and causeOut equals the external code (all ones, 15 by default). privMode is 1 and irqEnable is 0, and a redirect to 0x1004 is issued.
- R4: A valid instruction with a non-zero cause and no accepted interrupt does not retire. On the next cycle epcOut holds instPc when instIsFault is 0, or instPc+4 when instIsFault is 1. causeOut holds instCause, privMode is 1 and irqEnable is 0, and a redirect to 0x1004 is issued.
- R5: When an interrupt is accepted on an instruction with a non-zero cause, the interrupt wins. The instruction does not retire, epcOut becomes instPc so that the instruction runs again, causeOut becomes the external code, and the handler redirect is issued.
- R6: For an instruction with a non-zero cause, sbRelease equals instLateCause, which is set when the cause arose after register read.
- R7: While irqEnable is 0, extIrq has no effect, and an instruction with cause 0 retires with no redirect. A request that is still high is accepted by the first valid instruction after irqEnable returns to 1.
- R8: A return-from-trap (instIsEret=1, cause 0, no accepted interrupt) retires. It redirects to the current epcOut, sets privMode to 0 and irqEnable to 1, and leaves epcOut and causeOut unchanged.
- R9: A return-from-trap that meets an accepted interrupt does not retire and does not release the scoreboard. epcOut becomes its own instPc, causeOut becomes the external code, and the handler redirect is issued.
- R10: redirValid is a single-cycle pulse in the cycle after the deciding instruction. redirEpoch flips at every redirect and at no other time.
- R11: A cycle with instValid low asserts neither commitFire nor sbRelease and changes no state, whatever extIrq is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is at the retirement point this cycle |
| instPc | input | AW | Address of that instruction |
| instNextPc | input | AW | Address the instruction would continue to |
| instCause | input | CW | Recorded cause code, 0 for none |
| instIsFault | input | 1 | Cause is a fault or trap (instruction counts as complete) |
| instLateCause | input | 1 | Cause was detected after register read |
| instIsEret | input | 1 | Instruction is a return-from-trap |
| extIrq | input | 1 | Level-sensitive external interrupt request |
| commitFire | output | 1 | Instruction retires (register write and store may proceed) |
| sbRelease | output | 1 | Free the instruction's destination in the scoreboard |
| redirValid | output | 1 | One-cycle redirect strobe to fetch |
| redirPc | output | AW | Redirect target |
| redirEpoch | output | 1 | Epoch bit, flipped at every redirect |
| epcOut | output | AW | Saved return address |
| causeOut | output | CW | Trap cause register |
| privMode | output | 1 | 1 = privileged, 0 = user |
| irqEnable | output | 1 | External interrupts accepted when 1 |

## Verification
The hardest case to reach from the ports is a return-from-trap that meets an accepted interrupt. A return-from-trap normally runs inside the handler, where interrupts are masked. The collision can therefore happen only when the instruction arrives while the unit is already in user mode with interrupts enabled. The directed part of the stimulus builds exactly that state and then raises extIrq. It also covers a masked request that is held across a return-from-trap and is taken by the next instruction. The seeded random phase then mixes causes, fault flags, late-cause flags, returns and interrupt levels against a bench-side model of the registers.

// File: rtl/commit_pkg.sv
package commit_pkg;

  // which value the saved return address takes on trap entry
  typedef enum logic [1:0] {
    EPC_KEEP = 2'd0,
    EPC_NEXT = 2'd1,
    EPC_CUR  = 2'd2,
    EPC_CUR4 = 2'd3
  } epcSel_e;

  // strobes from the decision logic to the register datapath
  typedef struct packed {
    logic    commit;
    logic    sbRel;
    logic    enterTrap;
    logic    takeExt;
    logic    doEret;
    epcSel_e epcSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/commit_control.sv
module commit_control
  import commit_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          instValid,
  input  logic [CW-1:0] instCause,
  input  logic          instIsFault,
  input  logic          instLateCause,
  input  logic          instIsEret,
  input  logic          extIrq,
  input  logic          irqEnable,
  output ctrlStrobe_t   strb
);

  logic hasCause;
  logic takeIrq;

  assign hasCause = (instCause != '0);
  assign takeIrq  = instValid && extIrq && irqEnable;

  always_comb begin
    strb.commit    = 1'b0;
    strb.sbRel     = 1'b0;
    strb.enterTrap = 1'b0;
    strb.takeExt   = 1'b0;
    strb.doEret    = 1'b0;
    strb.epcSel    = EPC_KEEP;
    if (instValid) begin
      if (takeIrq) begin
        strb.enterTrap = 1'b1;
        strb.takeExt   = 1'b1;
        if (hasCause || instIsEret) begin
          // instruction is replayed after the handler
          strb.epcSel = EPC_CUR;
          strb.sbRel  = hasCause && instLateCause;
        end else begin
          strb.commit = 1'b1;
          strb.sbRel  = 1'b1;
          strb.epcSel = EPC_NEXT;
        end
      end else if (hasCause) begin
        strb.enterTrap = 1'b1;
        strb.sbRel     = instLateCause;
        strb.epcSel    = instIsFault ? EPC_CUR4 : EPC_CUR;
      end else if (instIsEret) begin
        strb.commit = 1'b1;
        strb.sbRel  = 1'b1;
        strb.doEret = 1'b1;
      end else begin
        strb.commit = 1'b1;
        strb.sbRel  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/commit_datapath.sv
module commit_datapath
  import commit_pkg::*;
#(
  parameter int              AW         = 32,
  parameter int              CW         = 4,
  parameter logic [AW-1:0]   HANDLER_PC = 32'h1004,
  parameter logic [CW-1:0]   EXT_CODE   = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic [AW-1:0] instPc,
  input  logic [AW-1:0] instNextPc,
  input  logic [CW-1:0] instCause,
  output logic [AW-1:0] epcQ,
  output logic [CW-1:0] causeQ,
  output logic          privQ,
  output logic          ieQ,
  output logic          redirValidQ,
  output logic [AW-1:0] redirPcQ,
  output logic          epochQ
);

  localparam logic [AW-1:0] INST_BYTES = AW'(4);

  logic [AW-1:0] epcNext;

  always_comb begin
    unique case (strb.epcSel)
      EPC_NEXT: epcNext = instNextPc;
      EPC_CUR:  epcNext = instPc;
      EPC_CUR4: epcNext = instPc + INST_BYTES;
      default:  epcNext = epcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ        <= '0;
      causeQ      <= '0;
      privQ       <= 1'b0;
      ieQ         <= 1'b1;
      redirValidQ <= 1'b0;
      redirPcQ    <= '0;
      epochQ      <= 1'b0;
    end else begin
      redirValidQ <= strb.enterTrap || strb.doEret;
      if (strb.enterTrap) begin
        epcQ     <= epcNext;
        causeQ   <= strb.takeExt ? EXT_CODE : instCause;
        privQ    <= 1'b1;
        ieQ      <= 1'b0;
        redirPcQ <= HANDLER_PC;
        epochQ   <= ~epochQ;
      end else if (strb.doEret) begin
        privQ    <= 1'b0;
        ieQ      <= 1'b1;
        redirPcQ <= epcQ;
        epochQ   <= ~epochQ;
      end
    end
  end

endmodule

// File: rtl/commit_trap_unit.sv
module commit_trap_unit
  import commit_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            CW         = 4,
  parameter logic [AW-1:0] HANDLER_PC = 32'h1004
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [AW-1:0] instPc,
  input  logic [AW-1:0] instNextPc,
  input  logic [CW-1:0] instCause,
  input  logic          instIsFault,
  input  logic          instLateCause,
  input  logic          instIsEret,
  input  logic          extIrq,
  output logic          commitFire,
  output logic          sbRelease,
  output logic          redirValid,
  output logic [AW-1:0] redirPc,
  output logic          redirEpoch,
  output logic [AW-1:0] epcOut,
  output logic [CW-1:0] causeOut,
  output logic          privMode,
  output logic          irqEnable
);

  localparam logic [CW-1:0] EXT_CODE = {CW{1'b1}};

  ctrlStrobe_t strb;

  commit_control #(.CW(CW)) u_ctrl (
    .instValid     (instValid),
    .instCause     (instCause),
    .instIsFault   (instIsFault),
    .instLateCause (instLateCause),
    .instIsEret    (instIsEret),
    .extIrq        (extIrq),
    .irqEnable     (irqEnable),
    .strb          (strb)
  );

  commit_datapath #(
    .AW(AW), .CW(CW), .HANDLER_PC(HANDLER_PC), .EXT_CODE(EXT_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .instPc      (instPc),
    .instNextPc  (instNextPc),
    .instCause   (instCause),
    .epcQ        (epcOut),
    .causeQ      (causeOut),
    .privQ       (privMode),
    .ieQ         (irqEnable),
    .redirValidQ (redirValid),
    .redirPcQ    (redirPc),
    .epochQ      (redirEpoch)
  );

  assign commitFire = strb.commit;
  assign sbRelease  = strb.sbRel;

endmodule

// File: rtl/commit_trap_checker.sv
module commit_trap_checker #(
  parameter int            AW         = 32,
  parameter int            CW         = 4,
  parameter logic [AW-1:0] HANDLER_PC = 32'h1004
) (
  input logic          clk,
  input logic          rstN,
  input logic          instValid,
  input logic [AW-1:0] instPc,
  input logic [AW-1:0] instNextPc,
  input logic [CW-1:0] instCause,
  input logic          instIsFault,
  input logic          instLateCause,
  input logic          instIsEret,
  input logic          extIrq,
  input logic          commitFire,
  input logic          sbRelease,
  input logic          redirValid,
  input logic [AW-1:0] redirPc,
  input logic          redirEpoch,
  input logic [AW-1:0] epcOut,
  input logic [CW-1:0] causeOut,
  input logic          privMode,
  input logic          irqEnable
);

  localparam logic [CW-1:0] EXT_CODE = {CW{1'b1}};

  // R2
  p_plain_retire_r2: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instCause == '0 && !instIsEret && !(extIrq && irqEnable)
      |-> commitFire && sbRelease);

  // R3 and R4 and R5
  p_trap_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    instValid && (instCause != '0 || (extIrq && irqEnable))
      |=> redirValid && redirPc == HANDLER_PC && privMode && !irqEnable);

  // R3 and R5 and R9
  p_ext_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    instValid && extIrq && irqEnable |=> causeOut == EXT_CODE);

  // R6
  p_sb_late_r6: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instCause != '0 |-> !commitFire && sbRelease == instLateCause);

  // R7
  p_masked_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !irqEnable && instCause == '0 && !instIsEret |=> !redirValid);

  // R8
  p_eret_r8: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instIsEret && instCause == '0 && !(extIrq && irqEnable)
      |=> redirValid && redirPc == $past(epcOut) && !privMode && irqEnable);

  // R10
  p_epoch_flip_r10: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> redirEpoch != $past(redirEpoch));

  // R11
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !commitFire && !sbRelease);

  p_idle_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !redirValid && $stable(epcOut) && $stable(causeOut));

endmodule

bind commit_trap_unit commit_trap_checker #(
  .AW(AW), .CW(CW), .HANDLER_PC(HANDLER_PC)
) u_chk (.*);

// File: tb/tb_commit_trap_unit.sv
module tb_commit_trap_unit;

  localparam int AW = 32;
  localparam int CW = 4;
  localparam logic [AW-1:0] HPC = 32'h1004;
  localparam logic [CW-1:0] EXT = 4'hF;

  logic          clk = 1'b0;
  logic          rstN;
  logic          instValid, instIsFault, instLateCause, instIsEret, extIrq;
  logic [AW-1:0] instPc, instNextPc;
  logic [CW-1:0] instCause;
  logic          commitFire, sbRelease, redirValid, redirEpoch, privMode, irqEnable;
  logic [AW-1:0] redirPc, epcOut;
  logic [CW-1:0] causeOut;

  int compared   = 0;
  int mismatched = 0;

  // bench-side model of the architectural registers
  logic [AW-1:0] mEpc, mRpc;
  logic [CW-1:0] mCause;
  logic          mPriv, mIe, mEpoch, mRv;

  always #10 clk = ~clk;

  commit_trap_unit dut (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input logic v, input logic [CW-1:0] c,
                                  input logic e, input logic irq, input logic ie);
    if (!v) return "R11";
    if (irq && ie) begin
      if (c != 0) return "R5";
      if (e) return "R9";
      return "R3";
    end
    if (c != 0) return "R4";
    if (irq) return "R7";
    if (e) return "R8";
    return "R2";
  endfunction

  // one instruction slot: drive, check strobes, clock, check registers
  task automatic slot(input logic v, input logic [AW-1:0] pc, input logic [AW-1:0] npc,
                      input logic [CW-1:0] c, input logic flt, input logic late,
                      input logic e, input logic irq);
    logic take, expCommit, expSb, trap, ret;
    logic [AW-1:0] newEpc;
    logic [CW-1:0] newCause;
    string t;
    instValid = v; instPc = pc; instNextPc = npc; instCause = c;
    instIsFault = flt; instLateCause = late; instIsEret = e; extIrq = irq;
    t = tagOf(v, c, e, irq, mIe);
    take = v && irq && mIe;
    trap = 1'b0; ret = 1'b0; expCommit = 1'b0; expSb = 1'b0;
    newEpc = mEpc; newCause = mCause;
    if (v) begin
      if (take) begin
        trap = 1'b1; newCause = EXT;
        if (c != 0 || e) begin newEpc = pc; expSb = (c != 0) && late; end
        else begin newEpc = npc; expCommit = 1'b1; expSb = 1'b1; end
      end else if (c != 0) begin
        trap = 1'b1; newCause = c; expSb = late;
        newEpc = flt ? pc + 32'd4 : pc;
      end else begin
        expCommit = 1'b1; expSb = 1'b1; ret = e;
      end
    end
    #1;
    chk(t, {31'b0, commitFire}, {31'b0, expCommit});
    chk((v && c != 0) ? "R6" : t, {31'b0, sbRelease}, {31'b0, expSb});
    @(posedge clk);
    mRv = trap || ret;
    if (trap) begin
      mEpc = newEpc; mCause = newCause; mPriv = 1'b1; mIe = 1'b0;
      mRpc = HPC; mEpoch = ~mEpoch;
    end else if (ret) begin
      mRpc = mEpc; mPriv = 1'b0; mIe = 1'b1; mEpoch = ~mEpoch;
    end
    @(negedge clk);
    chk(t, epcOut, mEpc);
    chk(t, {28'b0, causeOut}, {28'b0, mCause});
    chk(t, {31'b0, privMode}, {31'b0, mPriv});
    chk(t, {31'b0, irqEnable}, {31'b0, mIe});
    chk("R10", {31'b0, redirValid}, {31'b0, mRv});
    if (mRv) chk(t, redirPc, mRpc);
    chk("R10", {31'b0, redirEpoch}, {31'b0, mEpoch});
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rstN = 1'b0;
    instValid = 0; instPc = '0; instNextPc = '0; instCause = '0;
    instIsFault = 0; instLateCause = 0; instIsEret = 0; extIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", {31'b0, redirValid}, 32'd0);
    chk("R1", {31'b0, privMode}, 32'd0);
    chk("R1", {31'b0, irqEnable}, 32'd1);
    chk("R1", {28'b0, causeOut}, 32'd0);
    chk("R1", epcOut, 32'd0);
    chk("R1", {31'b0, redirEpoch}, 32'd0);
    mEpc = '0; mCause = '0; mPriv = 0; mIe = 1; mEpoch = 0; mRv = 0; mRpc = '0;

    slot(1, 32'h0080, 32'h0084, 0, 0, 0, 0, 0);   // R2
    slot(1, 32'h0100, 32'h0200, 0, 0, 0, 0, 1);   // R3 epc = next pc
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 0, 1);   // R7 masked
    slot(1, 32'h1008, 32'h100C, 0, 0, 0, 1, 1);   // R8 return
    slot(0, 32'h0200, 32'h0204, 0, 0, 0, 0, 1);   // R11 idle
    slot(1, 32'h0200, 32'h0204, 0, 0, 0, 0, 1);   // R7 pending request taken
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 1, 0);   // R8
    slot(1, 32'h0300, 32'h0304, 4'd3, 0, 1, 0, 0); // R4 exception, R6 late
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 1, 0);
    slot(1, 32'h0400, 32'h0408, 4'd5, 1, 0, 0, 0); // R4 fault, R6 early
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 1, 0);
    slot(1, 32'h0500, 32'h0504, 4'd2, 0, 1, 0, 1); // R5
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 1, 0);
    slot(1, 32'h0600, 32'h0604, 0, 0, 0, 1, 1);   // R9
    slot(1, 32'h1004, 32'h1008, 0, 0, 0, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pc;
      logic [CW-1:0] c;
      pc = $urandom & 32'hFFFF_FFFC;
      c  = ($urandom % 10 < 7) ? 4'd0 : CW'(1 + $urandom % 14);
      slot(($urandom % 10) < 8, pc, pc + 32'd4 + ($urandom % 4) * 32'd16, c,
           $urandom % 2, $urandom % 2, ($urandom % 8) == 0, ($urandom % 10) < 3);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule